// File: doc/BRIEF.md
# Smart Card Bit-Period Strobe Generator

This block produces the timing strobes that a smart card serial port needs to frame its bits. The length of one elementary time unit (ETU) is counted in card clock cycles and is the product of two programmed terms: a 16-bit base divisor, assembled from a high byte and a low byte, and an 8-bit clock-to-bit ratio. Only cycles in which the card clock enable is high are counted. The block strobes `etu_tick` at the end of every ETU and `mid_tick` at its midpoint, which a receiver uses to sample a bit.

Internally an inner counter runs over the base divisor and advances an outer counter over the ratio. An ETU ends when both wrap together. A separate position counter marks the midpoint. The divisor inputs are latched only at an ETU boundary, on a restart, or in the priming cycle after reset, so a write to them never shortens the ETU in progress. A restart pulse, issued when a start bit is detected, clears all counters so that the next boundary falls one full ETU after the restart. The controller has two states. `ST_PRIME` is entered from reset; it loads the divisors and clears the counters, then moves to `ST_RUN` on the next clock (transition PRIME→RUN). `ST_RUN` counts enabled cycles and stays in `ST_RUN` (transition RUN→RUN), including across restarts.

Top module: `sc_etu_gen`

## Requirements
- R1: While reset is asserted, and in the first clock after reset is released (the priming cycle, which loads the divisors and is not counted), `etu_tick` and `mid_tick` are both low.
- R2: With base B = {div_hi, div_lo} and ratio Q, one ETU lasts N = B×Q enabled card clock cycles. `etu_tick` is high for the one clock after the N-th, 2N-th, … enabled cycle, counted from priming or restart.
- R3: With div_hi = 8'h00, div_lo = 8'h1F and ratio = 8'h0C, the ETU is 31 × 12 = 372 enabled cycles long, which gives F/D = 372/1. A 3 MHz card clock therefore gives an ETU of 124 µs.
- R4: A clock edge where `card_clk_en` is low does not advance any counter. No strobe is high in the clock that follows it.
- R5: `mid_tick` is high for the one clock after the M-th enabled cycle of each ETU, where M = ceil(N/2).
- R6: A clock edge with `restart` high clears all counters and loads the divisor inputs. No strobe is high in the following clock. The next `etu_tick` follows the N-th enabled cycle after that edge.
- R7: A base value of zero is treated as 1, and a ratio of zero is treated as 1.
- R8: Changing the divisor inputs during an ETU does not change that ETU's length. The new values apply from the next ETU boundary, or from a restart.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| card_clk_en | input | 1 | One card clock period elapsed this cycle |
| restart | input | 1 | Realign the ETU grid to a start bit |
| div_hi | input | 8 | Base divisor, high byte |
| div_lo | input | 8 | Base divisor, low byte |
| ratio | input | 8 | Clock-to-bit ratio |
| etu_tick | output | 1 | ETU boundary strobe |
| mid_tick | output | 1 | Mid-ETU sample strobe |

## Verification
The assertions assume that `restart` and `card_clk_en` are synchronous to `clk` and hold stable for a whole cycle. They also assume that nothing else disturbs the counters between loads, so that the inner, outer and position counters always stay below the latched base, the latched ratio and the product. The bench drives every input at the falling edge and samples the strobes at the next falling edge. Each change to the divisor inputs is followed by either a restart or a full ETU before the bench expects the new length. Every ETU the bench checks fits well inside the run time.

// File: rtl/sc_etu_pkg.sv
package sc_etu_pkg;

    typedef enum logic [0:0] {
        ST_PRIME = 1'b0,
        ST_RUN   = 1'b1
    } etu_state_e;

endpackage

// File: rtl/sc_etu_cfg.sv
module sc_etu_cfg #(
    parameter int BASE_W  = 16,
    parameter int RATIO_W = 8,
    parameter logic [BASE_W-1:0]  BASE_RST  = 16'd31,
    parameter logic [RATIO_W-1:0] RATIO_RST = 8'd12,
    localparam int PROD_W = BASE_W + RATIO_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load,
    input  logic [BASE_W-1:0]  base_in,
    input  logic [RATIO_W-1:0] ratio_in,
    output logic [BASE_W-1:0]  base_q,
    output logic [RATIO_W-1:0] ratio_q,
    output logic [PROD_W-1:0]  len_o,
    output logic [PROD_W-1:0]  mid_o
);

    logic [BASE_W-1:0]  base_fix;
    logic [RATIO_W-1:0] ratio_fix;

    // Zero is mapped to 1 so the counters can always wrap
    always_comb begin
        base_fix  = (base_in  == '0) ? BASE_W'(1)  : base_in;
        ratio_fix = (ratio_in == '0) ? RATIO_W'(1) : ratio_in;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            base_q  <= BASE_RST;
            ratio_q <= RATIO_RST;
        end else if (load) begin
            base_q  <= base_fix;
            ratio_q <= ratio_fix;
        end
    end

    always_comb begin
        len_o = PROD_W'(base_q) * PROD_W'(ratio_q);
        mid_o = (len_o + PROD_W'(1)) >> 1;
    end

    // R7: latched terms are never zero
    a_r7_nonzero_terms: assert property (@(posedge clk) disable iff (!rst_n)
        (base_q != '0) && (ratio_q != '0));

    // R8: latched terms only move on a load
    a_r8_hold_between_loads: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> ($stable(base_q) && $stable(ratio_q)));

endmodule

// File: rtl/sc_etu_cnt.sv
module sc_etu_cnt #(
    parameter int BASE_W  = 16,
    parameter int RATIO_W = 8,
    localparam int PROD_W = BASE_W + RATIO_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clear,
    input  logic               step,
    input  logic [BASE_W-1:0]  base,
    input  logic [RATIO_W-1:0] ratio,
    input  logic [PROD_W-1:0]  len,
    input  logic [PROD_W-1:0]  mid,
    output logic               wrap,
    output logic               mid_hit
);

    logic [BASE_W-1:0]  inner_q;
    logic [RATIO_W-1:0] outer_q;
    logic [PROD_W-1:0]  pos_q;
    logic               inner_last;
    logic               outer_last;

    always_comb begin
        inner_last = (inner_q == base - BASE_W'(1));
        outer_last = (outer_q == ratio - RATIO_W'(1));
        wrap       = step && inner_last && outer_last;
        mid_hit    = step && (pos_q == mid - PROD_W'(1));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            inner_q <= '0;
            outer_q <= '0;
            pos_q   <= '0;
        end else if (clear) begin
            inner_q <= '0;
            outer_q <= '0;
            pos_q   <= '0;
        end else if (step) begin
            if (inner_last) begin
                inner_q <= '0;
                outer_q <= outer_last ? '0 : outer_q + RATIO_W'(1);
            end else begin
                inner_q <= inner_q + BASE_W'(1);
            end
            pos_q <= (inner_last && outer_last) ? '0 : pos_q + PROD_W'(1);
        end
    end

    // R2: counters stay inside the latched bounds
    a_r2_counters_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        (inner_q < base) && (outer_q < ratio) && (pos_q < len));

    // R4: without a step nothing moves
    a_r4_hold_without_step: assert property (@(posedge clk) disable iff (!rst_n)
        (!step && !clear) |=> ($stable(inner_q) && $stable(outer_q) && $stable(pos_q)));

endmodule

// File: rtl/sc_etu_gen.sv
module sc_etu_gen #(
    parameter int BASE_W  = 16,
    parameter int RATIO_W = 8,
    localparam int PROD_W = BASE_W + RATIO_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               card_clk_en,
    input  logic               restart,
    input  logic [7:0]         div_hi,
    input  logic [7:0]         div_lo,
    input  logic [RATIO_W-1:0] ratio,
    output logic               etu_tick,
    output logic               mid_tick
);
    import sc_etu_pkg::*;

    etu_state_e         state_q, state_d;
    logic               load, clear, step, wrap, mid_hit;
    logic [BASE_W-1:0]  base_q;
    logic [RATIO_W-1:0] ratio_q;
    logic [PROD_W-1:0]  len, mid;

    always_comb begin
        clear = (state_q == ST_PRIME) || restart;
        step  = (state_q == ST_RUN) && card_clk_en && !restart;
        load  = clear || wrap;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_PRIME: state_d = ST_RUN;
            ST_RUN:   state_d = ST_RUN;
            default:  state_d = ST_PRIME;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_PRIME;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            etu_tick <= 1'b0;
            mid_tick <= 1'b0;
        end else begin
            unique case (state_q)
                ST_PRIME: begin
                    etu_tick <= 1'b0;
                    mid_tick <= 1'b0;
                end
                ST_RUN: begin
                    etu_tick <= wrap;
                    mid_tick <= mid_hit;
                end
                default: begin
                    etu_tick <= 1'b0;
                    mid_tick <= 1'b0;
                end
            endcase
        end
    end

    sc_etu_cfg #(
        .BASE_W  (BASE_W),
        .RATIO_W (RATIO_W)
    ) u_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .base_in  (BASE_W'({div_hi, div_lo})),
        .ratio_in (ratio),
        .base_q   (base_q),
        .ratio_q  (ratio_q),
        .len_o    (len),
        .mid_o    (mid)
    );

    sc_etu_cnt #(
        .BASE_W  (BASE_W),
        .RATIO_W (RATIO_W)
    ) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (clear),
        .step    (step),
        .base    (base_q),
        .ratio   (ratio_q),
        .len     (len),
        .mid     (mid),
        .wrap    (wrap),
        .mid_hit (mid_hit)
    );

    // R6: no strobe right after a restart
    a_r6_quiet_after_restart: assert property (@(posedge clk) disable iff (!rst_n)
        $past(restart) |-> (!etu_tick && !mid_tick));

    // R4: a strobe needs an enabled card clock in the previous cycle
    a_r4_tick_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
        (etu_tick || mid_tick) |-> $past(card_clk_en));

    // R1: priming cycle emits nothing
    a_r1_prime_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_PRIME) |=> (!etu_tick && !mid_tick));

endmodule

// File: tb/tb_sc_etu_gen.sv
module tb_sc_etu_gen;
    localparam time CLK_PERIOD = 10ns;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       card_clk_en = 1'b0;
    logic       restart = 1'b0;
    logic [7:0] div_hi = 8'h00;
    logic [7:0] div_lo = 8'h1F;
    logic [7:0] ratio  = 8'h0C;
    logic       etu_tick, mid_tick;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sc_etu_gen dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .card_clk_en (card_clk_en),
        .restart     (restart),
        .div_hi      (div_hi),
        .div_lo      (div_lo),
        .ratio       (ratio),
        .etu_tick    (etu_tick),
        .mid_tick    (mid_tick)
    );

    task automatic check(input string req, input string what, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%b expected=%b at %0t", req, what, act, exp, $time);
        end
    endtask

    // Runs from a falling edge; k0 = enabled cycles already counted in this ETU
    task automatic run_window(input string req, input int n, input int m, input int k0,
                              input int cycles, input bit gaps);
        int k = k0;
        for (int i = 0; i < cycles; i++) begin
            card_clk_en = gaps ? ((i % 3) != 1) : 1'b1;
            @(posedge clk);
            @(negedge clk);
            if (card_clk_en) begin
                k++;
                check(req, "etu_tick", etu_tick, ((k % n) == 0));
                check(req, "mid_tick", mid_tick, ((((k - 1) % n) + 1) == m));
            end else begin
                check("R4", "etu_tick idle", etu_tick, 1'b0);
                check("R4", "mid_tick idle", mid_tick, 1'b0);
            end
        end
    endtask

    task automatic do_restart();
        restart = 1'b1;
        card_clk_en = 1'b1;
        @(posedge clk);
        @(negedge clk);
        restart = 1'b0;
        check("R6", "etu_tick after restart", etu_tick, 1'b0);
        check("R6", "mid_tick after restart", mid_tick, 1'b0);
    endtask

    task automatic t_reset_default();
        repeat (3) @(negedge clk);
        check("R1", "etu_tick in reset", etu_tick, 1'b0);
        check("R1", "mid_tick in reset", mid_tick, 1'b0);
        rst_n = 1'b1;
        card_clk_en = 1'b1;
        @(posedge clk);
        @(negedge clk);
        check("R1", "etu_tick prime", etu_tick, 1'b0);
        check("R1", "mid_tick prime", mid_tick, 1'b0);
        run_window("R3", 372, 186, 0, 744, 1'b0);
    endtask

    task automatic t_small_restart();
        div_hi = 8'h00; div_lo = 8'h03; ratio = 8'h02;
        do_restart();
        run_window("R2", 6, 3, 0, 18, 1'b0);
    endtask

    task automatic t_gaps();
        div_lo = 8'h05; ratio = 8'h01;
        do_restart();
        run_window("R5", 5, 3, 0, 30, 1'b1);
    endtask

    task automatic t_zero_terms();
        div_hi = 8'h00; div_lo = 8'h00; ratio = 8'h04;
        do_restart();
        run_window("R7", 4, 2, 0, 8, 1'b0);
        div_lo = 8'h03; ratio = 8'h00;
        do_restart();
        run_window("R7", 3, 2, 0, 6, 1'b0);
        div_lo = 8'h00; ratio = 8'h00;
        do_restart();
        run_window("R7", 1, 1, 0, 4, 1'b0);
    endtask

    task automatic t_change_mid_etu();
        div_hi = 8'h00; div_lo = 8'h03; ratio = 8'h02;
        do_restart();
        run_window("R8", 6, 3, 0, 2, 1'b0);
        div_lo = 8'h02; ratio = 8'h02;
        run_window("R8", 6, 3, 2, 4, 1'b0);
        run_window("R8", 4, 2, 0, 8, 1'b0);
    endtask

    task automatic t_restart_mid_etu();
        div_hi = 8'h00; div_lo = 8'h03; ratio = 8'h02;
        do_restart();
        run_window("R6", 6, 3, 0, 4, 1'b0);
        do_restart();
        run_window("R6", 6, 3, 0, 12, 1'b0);
    endtask

    initial begin
        t_reset_default();
        t_small_restart();
        t_gaps();
        t_zero_terms();
        t_change_mid_etu();
        t_restart_mid_etu();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule